// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This combinational unit sits at the front of a single-precision fused multiply-add pipe that computes z + x·y. It can also compute z − x·y. It decodes the raw bits of the three operands into classes. From those classes it decides whether the answer is already fixed by a special value: a NaN, an infinity, or a zero product. If it is, the unit produces the final 32-bit result and the invalid-operation flag. If it is not, it raises a request for the arithmetic datapath.

The multiply-subtract form is selected by a negate-product input. It is handled only by inverting the sign of the product. All conflicts between signed zeros and infinities are settled against that effective product sign. A two-bit rounding-mode input matters in one place only: the sign of an exact zero sum built from zeros of opposite sign.

Top module: `fma_special_resolve`

## Requirements
- R1: For every input combination exactly one of `special_vld` and `need_calc` is high.
- R2: If any operand is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the result is the first such operand in the order z, x, y, with fraction bit 22 set. `invalid` is high.
- R3: If no operand is a signalling NaN but some operand is a quiet NaN (fraction bit 22 set), the result is the first quiet NaN in the order z, x, y, unchanged. `invalid` is low.
- R4: Without NaNs, an infinite multiplicand paired with a zero multiplicand gives the default NaN 0x7FC00000 with `invalid` high.
- R5: The effective product sign is sign(x) XOR sign(y), inverted when `neg_prod` is 1. If the product is infinite and z is an infinity of the other sign, the result is 0x7FC00000 with `invalid` high.
- R6: In any other case with an infinite product, the result is an infinity carrying the effective product sign.
- R7: If the product is zero (one multiplicand zero, the other finite) and z is infinite, the result is z.
- R8: If the product is zero and z is a zero with the effective product sign, the result is z.
- R9: If the product is zero and z is a zero of the other sign, the result is +0 (0x00000000). When `rnd_mode` is 2'b11 (toward minus infinity) it is −0 (0x80000000).
- R10: If the product is zero and z is a nonzero finite value (normal or denormal), the result is z unchanged.
- R11: If both multiplicands are finite and nonzero and z is infinite, the result is z.
- R12: If both multiplicands are finite and nonzero and z is finite, `need_calc` is high, `special_res` is 0 and `invalid` is low.
- R13: `invalid` is raised only in the cases of R2, R4 and R5, and it is always accompanied by a NaN result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 32 | Addend bits |
| op_x | input | 32 | First multiplicand bits |
| op_y | input | 32 | Second multiplicand bits |
| neg_prod | input | 1 | 1 selects z − x·y |
| rnd_mode | input | 2 | Rounding mode; 2'b11 is toward minus infinity |
| special_vld | output | 1 | Result is fixed by special values |
| special_res | output | 32 | Fixed result, zero when not valid |
| invalid | output | 1 | Invalid-operation flag |
| need_calc | output | 1 | Operands go to the arithmetic datapath |

## Verification
The bench sweeps every triple drawn from two signed patterns of each class, under both product forms and all rounding modes. A resolver with the wrong NaN priority would return x's quiet NaN while z holds a signalling one, or would forget to quiet it. Mixing up the effective sign under `neg_prod` shows up as a spurious invalid on matching infinities, or as a wrong zero sign. A zero rule that ignores the rounding mode returns +0 where −0 is due. Denormal addends and denormal multiplicands must route correctly: a zero product must pass z through, while denormal times normal must request the datapath.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_DNRM = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;

  localparam int unsigned NUM_OPS = 3;
  localparam int unsigned IDX_Z   = 0;
  localparam int unsigned IDX_X   = 1;
  localparam int unsigned IDX_Y   = 2;
endpackage

// File: rtl/fma_sc_classify.sv
module fma_sc_classify
  import fma_sc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output fp_class_e             cls,
  output logic                  sgn
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              exp_min;
  logic              frac_nz;

  assign sgn     = op[W-1];
  assign exp_f   = op[W-2:FRAC_W];
  assign frac_f  = op[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)                cls = CLS_INF;
      else if (frac_f[FRAC_W-1])   cls = CLS_QNAN;
      else                         cls = CLS_SNAN;
    end else if (exp_min) begin
      cls = frac_nz ? CLS_DNRM : CLS_ZERO;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/fma_sc_nan_pick.sv
module fma_sc_nan_pick
  import fma_sc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] ops  [NUM_OPS],
  input  fp_class_e             clss [NUM_OPS],
  output logic                  hit,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  inv
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);

  // Later assignments override earlier ones: the quiet pass runs first,
  // the signalling pass second, each from the lowest priority operand up.
  always_comb begin
    hit = 1'b0;
    res = '0;
    inv = 1'b0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (clss[i] == CLS_QNAN) begin
        hit = 1'b1;
        res = ops[i];
      end
    end
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (clss[i] == CLS_SNAN) begin
        hit = 1'b1;
        res = ops[i] | QUIET_BIT;
        inv = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fma_sc_prod_rule.sv
module fma_sc_prod_rule
  import fma_sc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  fp_class_e             cls_z,
  input  fp_class_e             cls_x,
  input  fp_class_e             cls_y,
  input  logic                  sgn_z,
  input  logic                  sgn_x,
  input  logic                  sgn_y,
  input  logic [EXP_W+FRAC_W:0] op_z,
  input  logic                  neg_prod,
  input  logic                  rnd_down,
  output logic                  hit,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  inv,
  output logic                  calc
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic eff_sgn;
  logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;

  assign eff_sgn = sgn_x ^ sgn_y ^ neg_prod;
  assign x_inf   = (cls_x == CLS_INF);
  assign y_inf   = (cls_y == CLS_INF);
  assign x_zero  = (cls_x == CLS_ZERO);
  assign y_zero  = (cls_y == CLS_ZERO);
  assign z_inf   = (cls_z == CLS_INF);
  assign z_zero  = (cls_z == CLS_ZERO);

  always_comb begin
    hit  = 1'b1;
    res  = '0;
    inv  = 1'b0;
    calc = 1'b0;
    if ((x_inf && y_zero) || (x_zero && y_inf)) begin
      res = DFLT_NAN;
      inv = 1'b1;
    end else if (x_inf || y_inf) begin
      if (z_inf && (sgn_z != eff_sgn)) begin
        res = DFLT_NAN;
        inv = 1'b1;
      end else begin
        res = {eff_sgn, INF_MAG};
      end
    end else if (x_zero || y_zero) begin
      if (z_zero && (sgn_z != eff_sgn)) res = {rnd_down, {(W-1){1'b0}}};
      else                              res = op_z;
    end else if (z_inf) begin
      res = op_z;
    end else begin
      hit  = 1'b0;
      calc = 1'b1;
    end
  end
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fma_sc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter logic [1:0]  RM_DOWN = 2'b11
) (
  input  logic [EXP_W+FRAC_W:0] op_z,
  input  logic [EXP_W+FRAC_W:0] op_x,
  input  logic [EXP_W+FRAC_W:0] op_y,
  input  logic                  neg_prod,
  input  logic [1:0]            rnd_mode,
  output logic                  special_vld,
  output logic [EXP_W+FRAC_W:0] special_res,
  output logic                  invalid,
  output logic                  need_calc
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;

  logic [W-1:0] ops  [NUM_OPS];
  fp_class_e    clss [NUM_OPS];
  logic         sgns [NUM_OPS];

  assign ops[IDX_Z] = op_z;
  assign ops[IDX_X] = op_x;
  assign ops[IDX_Y] = op_y;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fma_sc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[g]),
      .cls (clss[g]),
      .sgn (sgns[g])
    );
  end

  logic         nan_hit, nan_inv;
  logic [W-1:0] nan_res;

  fma_sc_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .ops  (ops),
    .clss (clss),
    .hit  (nan_hit),
    .res  (nan_res),
    .inv  (nan_inv)
  );

  logic         pr_hit, pr_inv, pr_calc;
  logic [W-1:0] pr_res;

  fma_sc_prod_rule #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_prod (
    .cls_z    (clss[IDX_Z]),
    .cls_x    (clss[IDX_X]),
    .cls_y    (clss[IDX_Y]),
    .sgn_z    (sgns[IDX_Z]),
    .sgn_x    (sgns[IDX_X]),
    .sgn_y    (sgns[IDX_Y]),
    .op_z     (op_z),
    .neg_prod (neg_prod),
    .rnd_down (rnd_mode == RM_DOWN),
    .hit      (pr_hit),
    .res      (pr_res),
    .inv      (pr_inv),
    .calc     (pr_calc)
  );

  always_comb begin
    if (nan_hit) begin
      special_vld = 1'b1;
      special_res = nan_res;
      invalid     = nan_inv;
      need_calc   = 1'b0;
    end else begin
      special_vld = pr_hit;
      special_res = pr_res;
      invalid     = pr_inv;
      need_calc   = pr_calc;
    end
  end
endmodule

// File: rtl/fma_special_resolve_chk.sv
module fma_special_resolve_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input logic                  special_vld,
  input logic [EXP_W+FRAC_W:0] special_res,
  input logic                  invalid,
  input logic                  need_calc
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;

  logic res_is_nan;
  assign res_is_nan = (&special_res[W-2:FRAC_W]) && (|special_res[FRAC_W-1:0]);

  always_comb begin
    assert_one_path_R1: assert ($onehot({special_vld, need_calc}))
      else $error("special_vld and need_calc not exclusive");
    assert_invalid_special_R13: assert (!invalid || special_vld)
      else $error("invalid without special result");
    assert_invalid_nan_R13: assert (!invalid || res_is_nan)
      else $error("invalid with non-NaN result");
    assert_nan_quiet_R2: assert (!(special_vld && res_is_nan) || special_res[FRAC_W-1])
      else $error("signalling NaN left on output");
    assert_calc_idle_R12: assert (!need_calc || (special_res == '0 && !invalid))
      else $error("datapath request with live result");
  end
endmodule

bind fma_special_resolve fma_special_resolve_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .special_vld (special_vld),
  .special_res (special_res),
  .invalid     (invalid),
  .need_calc   (need_calc)
);

// File: tb/fma_special_resolve_tb.sv
module fma_special_resolve_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_z, op_x, op_y;
  logic        neg_prod;
  logic [1:0]  rnd_mode;
  logic        special_vld, invalid, need_calc;
  logic [31:0] special_res;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  fma_special_resolve u_dut (
    .op_z, .op_x, .op_y, .neg_prod, .rnd_mode,
    .special_vld, .special_res, .invalid, .need_calc
  );

  // class codes: 0 zero 1 denorm 2 normal 3 inf 4 qnan 5 snan
  function automatic int kind(input logic [31:0] v);
    if (v[30:23] == 8'hFF) return (v[22:0] == 0) ? 3 : (v[22] ? 4 : 5);
    if (v[30:23] == 8'h00) return (v[22:0] == 0) ? 0 : 1;
    return 2;
  endfunction

  logic [31:0] pats [12] = '{32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h8040_0000,
                            32'h3F80_0000, 32'hC040_0000, 32'h7F80_0000, 32'hFF80_0000,
                            32'h7FC0_0001, 32'hFFC1_2345, 32'h7F80_0001, 32'hFFA0_0010};

  task automatic check_one(input logic [31:0] z, x, y, input logic n, input logic [1:0] rm);
    logic [31:0] e_res;
    logic        e_vld, e_inv, e_calc, ps;
    string       tag;
    int kz, kx, ky;
    @(posedge clk);
    op_z = z; op_x = x; op_y = y; neg_prod = n; rnd_mode = rm;
    kz = kind(z); kx = kind(x); ky = kind(y);
    ps = x[31] ^ y[31] ^ n;
    e_vld = 1; e_inv = 0; e_calc = 0; e_res = 0;
    if (kz == 5 || kx == 5 || ky == 5) begin
      tag = "R2"; e_inv = 1;
      e_res = (kz == 5) ? z : (kx == 5) ? x : y;
      e_res[22] = 1'b1;
    end else if (kz == 4 || kx == 4 || ky == 4) begin
      tag = "R3"; e_res = (kz == 4) ? z : (kx == 4) ? x : y;
    end else if ((kx == 3 && ky == 0) || (kx == 0 && ky == 3)) begin
      tag = "R4"; e_inv = 1; e_res = 32'h7FC0_0000;
    end else if (kx == 3 || ky == 3) begin
      if (kz == 3 && z[31] != ps) begin tag = "R5"; e_inv = 1; e_res = 32'h7FC0_0000; end
      else begin tag = "R6"; e_res = {ps, 8'hFF, 23'd0}; end
    end else if (kx == 0 || ky == 0) begin
      if (kz == 3) begin tag = "R7"; e_res = z; end
      else if (kz == 0 && z[31] == ps) begin tag = "R8"; e_res = z; end
      else if (kz == 0) begin tag = "R9"; e_res = (rm == 2'b11) ? 32'h8000_0000 : 32'h0; end
      else begin tag = "R10"; e_res = z; end
    end else if (kz == 3) begin
      tag = "R11"; e_res = z;
    end else begin
      tag = "R12"; e_vld = 0; e_calc = 1;
    end
    @(negedge clk);
    n_chk++;
    if ({special_vld, need_calc, invalid, special_res} !== {e_vld, e_calc, e_inv, e_res}) begin
      n_bad++;
      $display("FAIL %s/R1/R13 z=%h x=%h y=%h n=%0d rm=%0d: got vld=%0d calc=%0d inv=%0d res=%h exp vld=%0d calc=%0d inv=%0d res=%h",
               tag, z, x, y, n, rm, special_vld, need_calc, invalid, special_res,
               e_vld, e_calc, e_inv, e_res);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op_z = '0; op_x = '0; op_y = '0; neg_prod = 1'b0; rnd_mode = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state after reset: +0 + (+0)(+0) resolves to +0 (R8)
    check_one(32'h0, 32'h0, 32'h0, 1'b0, 2'b00);
    for (int iz = 0; iz < 12; iz++)
      for (int ix = 0; ix < 12; ix++)
        for (int iy = 0; iy < 12; iy++)
          for (int nf = 0; nf < 2; nf++)
            for (int r = 0; r < 4; r++)
              check_one(pats[iz], pats[ix], pats[iy], nf[0], r[1:0]);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule